// File: doc/BRIEF.md
# Two-Level Page-Table Walker

This block fills translation-buffer misses in hardware. A miss arrives as a 32-bit virtual address with an access kind (load, store or instruction fetch) and a user/supervisor flag. The walker reads a descriptor from a 1024-entry top-level table whose base comes from a context root register. That descriptor either describes a 4 MB page directly or points to a 1024-entry second-level table, which is then read to reach a 4 KB page. The result is a physical address of up to 36 bits plus the page attribute flags, ready to be written into a TLB by the surrounding logic. No software trap is involved.

Rights are checked on the final descriptor. An invalid or malformed descriptor, a store to a read-only page, a fetch from a non-executable page, or a user access to a supervisor page ends the walk with a fault. The faulting virtual address is latched into a bad-address register and a fault code into an error-kind register. Writing the context root emits a one-cycle flush pulse for both translation buffers. Entries carrying the Global flag are expected to survive that flush in the buffers, so the flag is delivered with every refill. Descriptors are fetched one 32-bit word at a time over a request/valid read port.

Control is a six-state machine. IDLE accepts a miss and goes to READ_TOP. READ_TOP holds the read request until data returns, then goes to CHECK_TOP. CHECK_TOP goes to READ_LEAF when the descriptor is a table pointer, and to FINISH otherwise. READ_LEAF reads the second-level descriptor and goes to CHECK_LEAF. CHECK_LEAF goes to FINISH. FINISH reports the result for one cycle and returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1 and mem_req, done_valid, tlb_flush, err_code and bad_vaddr are all 0.
- R2: A root write while req_ready is 1 loads root_wdata as the root page number and raises tlb_flush for exactly the following cycle. A root write while a walk is in progress is ignored: no flush, and the root stays unchanged.
- R3: The first descriptor read uses address {root, vaddr[31:22], 2'b00}. mem_req stays high with a steady mem_addr until mem_rvalid is seen.
- R4: The descriptor layout is: bits [31:30] kind (00 invalid, 01 table pointer, 10 page, 11 reserved); bit 29 Cacheable, 28 Writable, 27 Executable, 26 User, 25 Global, 24 Dirty; bits [23:0] page number. A top-level pointer causes a second read at {pointer page number, vaddr[21:12], 2'b00}.
- R5: A page reached through the second level is a 4 KB page. done_paddr = {page number, vaddr[11:0]}, done_large = 0, and done_attr = descriptor bits [29:24].
- R6: A page kind found at the top level is a 4 MB page. done_paddr = {page number[23:10], vaddr[21:0]}, done_large = 1, and done_attr = descriptor bits [29:24].
- R7: Descriptor-kind faults use these codes: 1 = invalid at top level, 2 = invalid at second level, 3 = reserved kind, or a pointer kind at the second level.
- R8: Rights faults apply to a page descriptor, with req_acc 00 = load, 01 = store, 10 = fetch (11 = load). The checks in priority order are: user access to a page with User 0 gives code 4; store to a page with Writable 0 gives code 5; fetch from a page with Executable 0 gives code 6.
- R9: On a fault, done_fault is 1, done_paddr, done_attr and done_large are 0, and on the same edge bad_vaddr takes the virtual address and err_code takes the code. A walk that ends without a fault leaves both registers unchanged.
- R10: done_valid is a single-cycle pulse, and req_ready is 1 again in the cycle after it. mem_req is never high while req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_wr | input | 1 | Write strobe for the context root |
| root_wdata | input | 24 | New root page number |
| tlb_flush | output | 1 | One-cycle flush pulse for both translation buffers |
| req_valid | input | 1 | Miss request |
| req_ready | output | 1 | Walker idle and able to accept a miss |
| req_vaddr | input | 32 | Missing virtual address |
| req_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| req_user | input | 1 | Access made in user mode |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 36 | Descriptor byte address |
| mem_rvalid | input | 1 | Read data valid, ends the read |
| mem_rdata | input | 32 | Descriptor word |
| done_valid | output | 1 | Walk result valid (one cycle) |
| done_fault | output | 1 | Walk ended in a fault |
| done_large | output | 1 | Result is a 4 MB page |
| done_paddr | output | 36 | Translated physical address |
| done_attr | output | 6 | Flags {C, W, X, U, G, D} |
| bad_vaddr | output | 32 | Virtual address of the last fault |
| err_code | output | 4 | Code of the last fault |

## Verification
The bench exercises both page sizes with distinct offsets and page numbers. A walker that joined the page number and offset at the wrong split would return the wrong address for one size but not the other. It uses a descriptor that breaks two rights rules at once, a user store to a supervisor read-only page, to show that the privilege fault takes priority over the write fault. It also covers a pointer kind found at the second level, which a careless decoder would treat as a valid leaf. A root write is issued while a walk is in flight, and the bench checks that this does not redirect the next walk or raise a spurious flush. Finally, a successful walk follows a fault, and the bench checks that the error registers keep the old fault instead of being cleared.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ET_INVALID = 2'b00,
        ET_TABLE   = 2'b01,
        ET_LEAF    = 2'b10,
        ET_RSVD    = 2'b11
    } ent_kind_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_ALT   = 2'b11
    } acc_e;

    typedef enum logic [3:0] {
        FLT_NONE    = 4'd0,
        FLT_INV_TOP = 4'd1,
        FLT_INV_LF  = 4'd2,
        FLT_BADKIND = 4'd3,
        FLT_PRIV    = 4'd4,
        FLT_WRITE   = 4'd5,
        FLT_EXEC    = 4'd6
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_TOP,
        ST_CHECK_TOP,
        ST_READ_LEAF,
        ST_CHECK_LEAF,
        ST_FINISH
    } st_e;

    // flag offsets above the page-number field
    localparam int unsigned FLG_D = 0;
    localparam int unsigned FLG_G = 1;
    localparam int unsigned FLG_U = 2;
    localparam int unsigned FLG_X = 3;
    localparam int unsigned FLG_W = 4;
    localparam int unsigned FLG_C = 5;
    localparam int unsigned FLG_N = 6;

endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg #(
    parameter int unsigned PPN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             idle,
    input  logic [PPN_W-1:0] wdata,
    output logic [PPN_W-1:0] root,
    output logic             flush
);

    logic accept;
    assign accept = wr_en && idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root  <= '0;
            flush <= 1'b0;
        end else begin
            flush <= accept;
            if (accept) begin
                root <= wdata;
            end
        end
    end

    AST_ROOT_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(root)); // R2
    AST_FLUSH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idle) |=> flush && root == $past(wdata)); // R2

endmodule

// File: rtl/ptw_desc_addr.sv
module ptw_desc_addr #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned PPN_W = 24,
    parameter int unsigned IDX_W = 10,
    localparam int unsigned OFF_W = VA_W - 2*IDX_W,
    localparam int unsigned PA_W  = PPN_W + OFF_W,
    localparam int unsigned PAD_W = OFF_W - IDX_W
) (
    input  logic [PPN_W-1:0] root,
    input  logic [PPN_W-1:0] tbl_ppn,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             second,
    output logic [PA_W-1:0]  addr
);

    logic [IDX_W-1:0] idx_top;
    logic [IDX_W-1:0] idx_leaf;
    logic [PPN_W-1:0] base;
    logic [IDX_W-1:0] idx;

    assign idx_top  = vaddr[VA_W-1 -: IDX_W];
    assign idx_leaf = vaddr[VA_W-IDX_W-1 -: IDX_W];
    assign base     = second ? tbl_ppn : root;
    assign idx      = second ? idx_leaf : idx_top;

    generate
        if (PAD_W > 0) begin : g_pad
            assign addr = {base, idx, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign addr = {base, idx};
        end
    endgenerate

endmodule

// File: rtl/ptw_rights.sv
module ptw_rights
    import ptw_pkg::*;
#(
    parameter int unsigned PPN_W = 24,
    localparam int unsigned DESC_W = PPN_W + FLG_N + 2,
    localparam int unsigned KIND_LO = PPN_W + FLG_N
) (
    input  logic [DESC_W-1:0] desc,
    input  logic              second,
    input  acc_e              acc,
    input  logic              user,
    output flt_e              code
);

    ent_kind_e kind;
    logic      f_u;
    logic      f_w;
    logic      f_x;

    assign kind = ent_kind_e'(desc[KIND_LO+1:KIND_LO]);
    assign f_u  = desc[PPN_W+FLG_U];
    assign f_w  = desc[PPN_W+FLG_W];
    assign f_x  = desc[PPN_W+FLG_X];

    always_comb begin
        code = FLT_NONE;
        unique case (kind)
            ET_INVALID: code = second ? FLT_INV_LF : FLT_INV_TOP;
            ET_TABLE:   code = FLT_BADKIND;
            ET_RSVD:    code = FLT_BADKIND;
            ET_LEAF: begin
                if (user && !f_u) begin
                    code = FLT_PRIV;
                end else if (acc == ACC_STORE && !f_w) begin
                    code = FLT_WRITE;
                end else if (acc == ACC_FETCH && !f_x) begin
                    code = FLT_EXEC;
                end
            end
            default: code = FLT_BADKIND;
        endcase
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned PPN_W = 24,
    parameter int unsigned IDX_W = 10,
    localparam int unsigned OFF_W  = VA_W - 2*IDX_W,
    localparam int unsigned PA_W   = PPN_W + OFF_W,
    localparam int unsigned DESC_W = PPN_W + FLG_N + 2,
    localparam int unsigned ERR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              root_wr,
    input  logic [PPN_W-1:0]  root_wdata,
    output logic              tlb_flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              done_valid,
    output logic              done_fault,
    output logic              done_large,
    output logic [PA_W-1:0]   done_paddr,
    output logic [FLG_N-1:0]  done_attr,
    output logic [VA_W-1:0]   bad_vaddr,
    output logic [ERR_W-1:0]  err_code
);

    localparam int unsigned BIG_OFF = OFF_W + IDX_W;
    localparam int unsigned BIG_HI  = PA_W - BIG_OFF;
    localparam int unsigned KIND_LO = PPN_W + FLG_N;

    st_e               state;
    st_e               state_nx;
    logic [VA_W-1:0]   va_q;
    acc_e              acc_q;
    logic              user_q;
    logic [DESC_W-1:0] desc_q;
    logic              lvl2_q;
    logic [PPN_W-1:0]  root;
    flt_e              code;
    ent_kind_e         kind_q;
    logic [PPN_W-1:0]  leaf_ppn;
    logic [PA_W-1:0]   pa_small;
    logic [PA_W-1:0]   pa_big;
    logic              idle;

    assign idle     = (state == ST_IDLE);
    assign kind_q   = ent_kind_e'(desc_q[KIND_LO+1:KIND_LO]);
    assign leaf_ppn = desc_q[PPN_W-1:0];
    assign pa_small = {leaf_ppn, va_q[OFF_W-1:0]};
    assign pa_big   = {leaf_ppn[PPN_W-1 -: BIG_HI], va_q[BIG_OFF-1:0]};

    ptw_root_reg #(.PPN_W(PPN_W)) u_root (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (root_wr),
        .idle  (idle),
        .wdata (root_wdata),
        .root  (root),
        .flush (tlb_flush)
    );

    ptw_desc_addr #(.VA_W(VA_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_addr (
        .root    (root),
        .tbl_ppn (desc_q[PPN_W-1:0]),
        .vaddr   (va_q),
        .second  (lvl2_q),
        .addr    (mem_addr)
    );

    ptw_rights #(.PPN_W(PPN_W)) u_rights (
        .desc   (desc_q),
        .second (lvl2_q),
        .acc    (acc_q),
        .user   (user_q),
        .code   (code)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (req_valid) state_nx = ST_READ_TOP;
            ST_READ_TOP:   if (mem_rvalid) state_nx = ST_CHECK_TOP;
            ST_CHECK_TOP:  state_nx = (kind_q == ET_TABLE) ? ST_READ_LEAF : ST_FINISH;
            ST_READ_LEAF:  if (mem_rvalid) state_nx = ST_CHECK_LEAF;
            ST_CHECK_LEAF: state_nx = ST_FINISH;
            ST_FINISH:     state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // walk context and fault registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            acc_q     <= ACC_LOAD;
            user_q    <= 1'b0;
            desc_q    <= '0;
            lvl2_q    <= 1'b0;
            bad_vaddr <= '0;
            err_code  <= '0;
        end else begin
            if (idle && req_valid) begin
                va_q   <= req_vaddr;
                acc_q  <= acc_e'(req_acc);
                user_q <= req_user;
                lvl2_q <= 1'b0;
            end
            if ((state == ST_READ_TOP || state == ST_READ_LEAF) && mem_rvalid) begin
                desc_q <= mem_rdata;
            end
            if (state == ST_CHECK_TOP && kind_q == ET_TABLE) begin
                lvl2_q <= 1'b1;
            end
            if (state == ST_FINISH && code != FLT_NONE) begin
                bad_vaddr <= va_q;
                err_code  <= code;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        mem_req    = 1'b0;
        done_valid = 1'b0;
        done_fault = 1'b0;
        done_large = 1'b0;
        done_paddr = '0;
        done_attr  = '0;
        unique case (state)
            ST_IDLE:      req_ready = 1'b1;
            ST_READ_TOP:  mem_req   = 1'b1;
            ST_READ_LEAF: mem_req   = 1'b1;
            ST_FINISH: begin
                done_valid = 1'b1;
                if (code != FLT_NONE) begin
                    done_fault = 1'b1;
                end else begin
                    done_large = !lvl2_q;
                    done_paddr = lvl2_q ? pa_small : pa_big;
                    done_attr  = desc_q[PPN_W +: FLG_N];
                end
            end
            default: ;
        endcase
    end

    AST_MEM_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> mem_req && $stable(mem_addr)); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid && req_ready); // R10
    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req); // R10
    AST_FAULT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |-> (done_paddr == '0 && done_attr == '0 && !done_large)); // R9
    AST_FAULT_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |=> (bad_vaddr == $past(va_q) && err_code != '0)); // R9
    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && done_fault) |=> ($stable(err_code) && $stable(bad_vaddr))); // R9
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> err_code <= 4'd6); // R7

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

    typedef struct packed {
        logic [23:0] root;
        logic [31:0] va;
        logic [1:0]  acc;
        logic        user;
        logic [31:0] d1;
        logic [31:0] d2;
        logic [3:0]  err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{24'h000100, 32'h0040_3ABC, 2'b00, 1'b0, 32'h4000_0222, 32'hB012_3456, 4'd0},
        '{24'h00ABC0, 32'hC0A1_2345, 2'b10, 1'b1, 32'h8EAB_CDEF, 32'h0000_0000, 4'd0},
        '{24'h000100, 32'h0040_3ABC, 2'b01, 1'b0, 32'h4000_0222, 32'hA112_3456, 4'd5},
        '{24'h000200, 32'h1234_5678, 2'b10, 1'b0, 32'h4000_0333, 32'h9000_0777, 4'd6},
        '{24'h000100, 32'h0040_3ABC, 2'b01, 1'b1, 32'h4000_0222, 32'hA112_3456, 4'd4},
        '{24'h000300, 32'hFFFF_F000, 2'b00, 1'b0, 32'h0000_0000, 32'h0000_0000, 4'd1},
        '{24'h000300, 32'h0080_1000, 2'b00, 1'b0, 32'h4000_0444, 32'h0000_0000, 4'd2},
        '{24'h000300, 32'h0080_1000, 2'b00, 1'b0, 32'hC000_0000, 32'h0000_0000, 4'd3},
        '{24'h000300, 32'h0080_1000, 2'b00, 1'b0, 32'h4000_0555, 32'h4000_0666, 4'd3},
        '{24'h000400, 32'h7FFF_FFFF, 2'b01, 1'b1, 32'h9512_3400, 32'h0000_0000, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_wr = 1'b0;
    logic [23:0] root_wdata = '0;
    logic        tlb_flush;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        mem_req;
    logic [35:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        done_valid;
    logic        done_fault;
    logic        done_large;
    logic [35:0] done_paddr;
    logic [5:0]  done_attr;
    logic [31:0] bad_vaddr;
    logic [3:0]  err_code;

    int n_chk = 0;
    int n_bad = 0;
    logic [35:0] l1a, l2a;
    logic [31:0] m_d1, m_d2;
    int          mem_lat = 0;
    int          wcnt = 0;
    logic [31:0] mdl_bad = '0;
    logic [3:0]  mdl_err = '0;

    always #10 clk = ~clk;  // 50 MHz

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .root_wr(root_wr), .root_wdata(root_wdata),
        .tlb_flush(tlb_flush), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done_valid(done_valid), .done_fault(done_fault),
        .done_large(done_large), .done_paddr(done_paddr), .done_attr(done_attr),
        .bad_vaddr(bad_vaddr), .err_code(err_code)
    );

    // descriptor memory with programmable wait
    always_ff @(posedge clk) begin
        if (!mem_req || mem_rvalid) wcnt <= 0;
        else wcnt <= wcnt + 1;
    end
    assign mem_rvalid = mem_req && (wcnt >= mem_lat);
    always_comb begin
        if (mem_addr == l1a)      mem_rdata = m_d1;
        else if (mem_addr == l2a) mem_rdata = m_d2;
        else                      mem_rdata = 32'h0;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_root(input logic [23:0] r);
        @(negedge clk);
        root_wr = 1'b1;
        root_wdata = r;
        @(negedge clk);
        root_wr = 1'b0;
        check("R2 flush pulse", tlb_flush, 1);
        @(negedge clk);
        check("R2 flush ends", tlb_flush, 0);
    endtask

    task automatic load_mem(input vec_t v, input int lat);
        l1a = {v.root, v.va[31:22], 2'b00};
        l2a = {v.d1[23:0], v.va[21:12], 2'b00};
        m_d1 = v.d1;
        m_d2 = v.d2;
        mem_lat = lat;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        if (!done_valid) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 walk never finished actual=0 expected=1");
        end
    endtask

    task automatic run_vec(input vec_t v, input int lat);
        logic        big;
        logic [31:0] leaf;
        logic [35:0] epa;
        string       tag;
        load_mem(v, lat);
        big  = (v.d1[31:30] == 2'b10);
        leaf = big ? v.d1 : v.d2;
        epa  = big ? {leaf[23:10], v.va[21:0]} : {leaf[23:0], v.va[11:0]};
        if (v.err inside {4'd1, 4'd2, 4'd3}) tag = "R7";
        else if (v.err != 0) tag = "R8";
        else if (big) tag = "R6";
        else tag = "R5";
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = v.va;
        req_acc = v.acc;
        req_user = v.user;
        @(negedge clk);
        req_valid = 1'b0;
        check("R3 top read request", mem_req, 1);
        check("R3 top read address", mem_addr, l1a);
        wait_done();
        check({tag, " fault code"}, {done_fault, 4'(v.err)}, {v.err != 0, v.err});
        if (v.err == 0) begin
            check({tag, " physical address"}, done_paddr, epa);
            check({tag, " R4 attributes"}, {done_large, done_attr}, {big, leaf[29:24]});
        end else begin
            check("R9 blanked result", {done_large, done_attr, done_paddr}, 0);
            mdl_bad = v.va;
            mdl_err = v.err;
        end
        @(negedge clk);
        check("R10 done single cycle, ready back", {done_valid, req_ready}, 2'b01);
        check("R9 bad address register", bad_vaddr, mdl_bad);
        check("R9 error code register", err_code, mdl_err);
    endtask

    initial begin
        m_d1 = '0; m_d2 = '0; l1a = '1; l2a = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ready/idle outputs", {req_ready, mem_req, done_valid, tlb_flush}, 4'b1000);
        check("R1 reset error registers", {err_code, bad_vaddr}, 0);

        for (int i = 0; i < NV; i++) begin
            set_root(VECS[i].root);
            run_vec(VECS[i], i % 3);
        end

        // root write during a walk is ignored
        set_root(VECS[0].root);
        load_mem(VECS[0], 4);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = VECS[0].va;
        req_acc = 2'b00;
        req_user = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        root_wr = 1'b1;
        root_wdata = 24'h0F0F0F;
        @(negedge clk);
        root_wr = 1'b0;
        check("R2 no flush while busy", tlb_flush, 0);
        wait_done();
        check("R2 walk unaffected by busy write", done_fault, 0);
        @(negedge clk);
        run_vec(VECS[0], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule